// File: doc/BRIEF.md
# SPI register file slave

This block is the serial control port of a mixed-signal device. A host reaches a 32-entry byte-wide register space over a serial clock, an active-low frame enable and one or two data lines. Every frame opens with an instruction byte that names the direction, the number of data bytes (one to four) and a starting address. One data byte follows for each address, and the address steps downward after each byte. Reads can return data on the shared bidirectional line (3-wire use) or on a separate output line (4-wire use). A bit in the configuration space selects between the two.

Eight configuration bytes drive the device through a flat output bus. Each of these bytes is stored in three independent copies. A bitwise majority vote of the copies feeds the outputs and the readback. A status bit reports any disagreement between the copies. The other addresses hold a temperature code taken from an input port, a zero-reading reserved byte, a 64-bit identifier, a revision byte, and a range of unimplemented addresses.

Top module: `spi_regfile_slave`

## Requirements
- R1: The instruction byte holds the direction in bit 7 (1 = read, 0 = write), the data-byte count code in bits 6:5 and the start address in bits 4:0.
- R2: Count codes 0, 1, 2 and 3 move 1, 2, 3 and 4 data bytes. Further bytes in the same frame are ignored.
- R3: Bits are sent MSB first. Input bits are sampled on rising `sclk` edges, and read bits change on falling `sclk` edges.
- R4: The address steps down by one after each data byte and wraps from 0x00 to 0x1F.
- R5: After reset, configuration byte 0x05 reads 0x20, byte 0x06 reads 0x04, and bytes 0x00–0x04 and 0x07 read 0x00.
- R6: When bit 3 of register 0x01 is 1 (4-wire), read data leaves on `sdo_out` with `sdo_oe` high and `sdio_oe` low. When the bit is 0 (3-wire), read data leaves on `sdio_out` with `sdio_oe` high and `sdo_oe` low.
- R7: After the last data bit of a read, from the next falling edge until `csn` rises, `sdo_out` is driven low (4-wire) or `sdio_oe` is released (3-wire). While `csn` is high, both enables are low.
- R8: Writes to addresses 0x08–0x1F change nothing. Addresses 0x0A–0x16 read 0x00. Addresses 0x17–0x1E read the identifier bytes (0x17 = bits 7:0 upward), and 0x1F reads the revision byte.
- R9: Address 0x08 reads the current value of `temp_code`.
- R10: Bit 0 of address 0x09 is 1 while any copy of the configuration bytes disagrees with another. The outputs and readback follow the majority of the copies. A write refreshes all three copies of its byte.
- R11: If `csn` rises before the eighth bit of a data byte, that byte has no effect.
- R12: `cfg_out` holds configuration byte k at bits 8k+7:8k. Each byte updates on the rising edge that samples its last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register contents |
| csn | input | 1 | Active-low frame enable |
| sdio_in | input | 1 | Serial data into the block (either wiring) |
| sdio_out | output | 1 | Read data for the shared line in 3-wire use |
| sdio_oe | output | 1 | Drive enable of the shared line |
| sdo_out | output | 1 | Read data line in 4-wire use |
| sdo_oe | output | 1 | Drive enable of `sdo_out` |
| temp_code | input | 8 | Temperature code presented at address 0x08 |
| cfg_out | output | 64 | Voted configuration bytes 0x00–0x07 |

## Verification
A write lands in `cfg_out` at the rising edge that samples its eighth data bit, so the bench compares the configuration bus only after the frame has closed. Each read bit appears half a clock period after the rising edge that completes the previous bit. The monitor samples the output line a quarter period after every falling edge, and it pops one expected byte from the scoreboard for each group of eight bits. The end-of-read behaviour is due at the falling edge after the final data bit, and the bench checks it at that edge. Line release is checked a quarter period after `csn` rises.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int NCFG    = 8;
  localparam int CFG_W   = NCFG * BYTE_W;
  localparam int ID_W    = 64;
  localparam int CNT_W   = 3;

  localparam logic [ADDR_W-1:0] A_TEMP     = 5'h08;
  localparam logic [ADDR_W-1:0] A_ERR      = 5'h09;
  localparam logic [ADDR_W-1:0] A_ID_FIRST = 5'h17;
  localparam logic [ADDR_W-1:0] A_ID_LAST  = 5'h1E;
  localparam logic [ADDR_W-1:0] A_REV      = 5'h1F;
  localparam int MODE_POS = 1 * BYTE_W + 3;

  typedef struct packed {
    logic              rd;
    logic [1:0]        cnt;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  function automatic logic [CNT_W-1:0] xfer_len(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_reset();
    logic [CFG_W-1:0] v;
    v = '0;
    v[5*BYTE_W +: BYTE_W] = 8'h20;
    v[6*BYTE_W +: BYTE_W] = 8'h04;
    return v;
  endfunction

  function automatic logic [CFG_W-1:0] vote3(input logic [CFG_W-1:0] a,
                                             input logic [CFG_W-1:0] b,
                                             input logic [CFG_W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic [ID_W-1:0] id,
                                                input logic [ADDR_W-1:0] a);
    logic [2:0] k;
    k = 3'(a - A_ID_FIRST);
    return id[{k, 3'b000} +: BYTE_W];
  endfunction
endpackage

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
(
  input  logic              sclk,
  input  logic              frame_clr,
  input  logic              sdi,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rd_frame,
  output logic              in_data,
  output logic              in_tail,
  output logic              bit_zero
);
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  byte_q;
  logic [BYTE_W-2:0] sh_q;
  instr_t            ins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_end;
  logic [CNT_W-1:0]  len;

  assign byte_in  = {sh_q, sdi};
  assign byte_end = (bit_q == BIT_W'(BYTE_W - 1));
  assign len      = xfer_len(ins_q.cnt);
  assign in_data  = (byte_q != '0) && (byte_q <= len);
  assign in_tail  = (byte_q > len);
  assign rd_frame = ins_q.rd;
  assign bit_zero = (bit_q == '0);
  assign cur_addr = addr_q;
  assign wr_data  = byte_in;
  assign wr_stb   = byte_end && in_data && !ins_q.rd;

  always_ff @(posedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      ins_q  <= '0;
      addr_q <= '0;
    end else begin
      bit_q <= bit_q + 1'b1;
      sh_q  <= byte_in[BYTE_W-2:0];
      if (byte_end) begin
        if (byte_q == '0) begin
          ins_q  <= instr_t'(byte_in);
          addr_q <= byte_in[ADDR_W-1:0];
        end else begin
          addr_q <= addr_q - 1'b1;
        end
        if (byte_q != '1) byte_q <= byte_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_rf_bank.sv
module spi_rf_bank
  import spi_rf_pkg::*;
#(
  parameter int               N_BYTES = NCFG,
  parameter logic [N_BYTES*BYTE_W-1:0] RST_VAL = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(N_BYTES)-1:0]    idx,
  input  logic [BYTE_W-1:0]             wbyte,
  output logic [N_BYTES*BYTE_W-1:0]     mem_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem_q <= RST_VAL;
    else if (we) mem_q[idx*BYTE_W +: BYTE_W] <= wbyte;
  end
endmodule

// File: rtl/spi_rf_cfg_tmr.sv
module spi_rf_cfg_tmr
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CFG_W-1:0]  voted,
  output logic              mismatch
);
  localparam int NCOPY = 3;
  localparam int IDX_W = $clog2(NCFG);

  logic                        cfg_we;
  logic [IDX_W-1:0]            widx;
  logic [NCOPY-1:0][CFG_W-1:0] copy_q;

  assign cfg_we = wr_stb && (wr_addr < ADDR_W'(NCFG));
  assign widx   = wr_addr[IDX_W-1:0];

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    spi_rf_bank #(.N_BYTES(NCFG), .RST_VAL(cfg_reset())) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (widx),
      .wbyte (wr_data),
      .mem_q (copy_q[g])
    );
  end

  assign voted    = vote3(copy_q[0], copy_q[1], copy_q[2]);
  assign mismatch = |((copy_q[0] ^ copy_q[1]) | (copy_q[0] ^ copy_q[2]));
endmodule

// File: rtl/spi_rf_tx.sv
module spi_rf_tx
  import spi_rf_pkg::*;
(
  input  logic              sclk,
  input  logic              frame_clr,
  input  logic              rd_frame,
  input  logic              in_data,
  input  logic              in_tail,
  input  logic              bit_zero,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              tx_bit,
  output logic              drive_q,
  output logic              tail_q
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(negedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      sh_q    <= '0;
      drive_q <= 1'b0;
      tail_q  <= 1'b0;
    end else if (rd_frame && in_data) begin
      if (bit_zero) begin
        sh_q    <= rd_byte;
        drive_q <= 1'b1;
      end else begin
        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
    end else if (rd_frame && in_tail) begin
      sh_q    <= '0;
      drive_q <= 1'b1;
      tail_q  <= 1'b1;
    end
  end

  assign tx_bit = sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter logic [ID_W-1:0]   DIE_ID  = 64'hC3A5_1E2F_7B90_4D68,
  parameter logic [BYTE_W-1:0] DIE_REV = 8'h5A
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  input  logic [BYTE_W-1:0] temp_code,
  output logic [CFG_W-1:0]  cfg_out
);
  localparam int IDX_W = $clog2(NCFG);

  logic              frame_clr;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_frame, in_data, in_tail, bit_zero;
  logic              mem_err;
  logic              four_wire;
  logic [BYTE_W-1:0] rd_byte;
  logic              tx_bit, drive_q, tail_q;

  assign frame_clr = csn | ~rst_n;

  spi_rf_frame u_frame (
    .sclk      (sclk),
    .frame_clr (frame_clr),
    .sdi       (sdio_in),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .cur_addr  (wr_addr),
    .rd_frame  (rd_frame),
    .in_data   (in_data),
    .in_tail   (in_tail),
    .bit_zero  (bit_zero)
  );

  spi_rf_cfg_tmr u_cfg (
    .clk      (sclk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .voted    (cfg_out),
    .mismatch (mem_err)
  );

  always_comb begin
    rd_byte = '0;
    if (wr_addr < ADDR_W'(NCFG))
      rd_byte = cfg_out[wr_addr[IDX_W-1:0]*BYTE_W +: BYTE_W];
    else if (wr_addr == A_TEMP)
      rd_byte = temp_code;
    else if (wr_addr == A_ERR)
      rd_byte = {{(BYTE_W-1){1'b0}}, mem_err};
    else if (wr_addr >= A_ID_FIRST && wr_addr <= A_ID_LAST)
      rd_byte = id_byte(DIE_ID, wr_addr);
    else if (wr_addr == A_REV)
      rd_byte = DIE_REV;
  end

  spi_rf_tx u_tx (
    .sclk      (sclk),
    .frame_clr (frame_clr),
    .rd_frame  (rd_frame),
    .in_data   (in_data),
    .in_tail   (in_tail),
    .bit_zero  (bit_zero),
    .rd_byte   (rd_byte),
    .tx_bit    (tx_bit),
    .drive_q   (drive_q),
    .tail_q    (tail_q)
  );

  assign four_wire = cfg_out[MODE_POS];
  assign sdo_oe    = drive_q & four_wire;
  assign sdo_out   = drive_q & four_wire & tx_bit;
  assign sdio_oe   = drive_q & ~four_wire & ~tail_q;
  assign sdio_out  = tx_bit;
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk
  import spi_rf_pkg::*;
(
  input logic              sclk,
  input logic              rst_n,
  input logic              csn,
  input logic              sdo_oe,
  input logic              sdio_oe,
  input logic              sdo_out,
  input logic              tail_q,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [CFG_W-1:0]  cfg_out
);
  logic              lw_valid;
  logic [2:0]        lw_addr;
  logic [BYTE_W-1:0] lw_data;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      lw_valid <= 1'b0;
      lw_addr  <= '0;
      lw_data  <= '0;
    end else if (wr_stb && wr_addr < 5'd8) begin
      lw_valid <= 1'b1;
      lw_addr  <= wr_addr[2:0];
      lw_data  <= wr_data;
    end
  end

  AST_RESET_VALUES: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_out == cfg_reset());                                  // R5
  AST_IDLE_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    csn |-> (!sdo_oe && !sdio_oe));                                            // R7
  AST_TAIL_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
    tail_q |-> (!sdo_out && !sdio_oe));                                        // R7
  AST_IGNORED_WRITE: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_stb && wr_addr >= 5'd8) |=> $stable(cfg_out));                         // R8
  AST_LAST_WRITE_HELD: assert property (@(posedge sclk) disable iff (!rst_n)
    lw_valid |-> cfg_out[{lw_addr, 3'b000} +: BYTE_W] == lw_data);            // R12
endmodule

bind spi_regfile_slave spi_regfile_slave_chk u_chk (
  .sclk    (sclk),
  .rst_n   (rst_n),
  .csn     (csn),
  .sdo_oe  (sdo_oe),
  .sdio_oe (sdio_oe),
  .sdo_out (sdo_out),
  .tail_q  (tail_q),
  .wr_stb  (wr_stb),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .cfg_out (cfg_out)
);

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
  localparam int PER = 10;
  localparam logic [63:0] ID  = 64'h0F1E_2D3C_4B5A_6978;
  localparam logic [7:0]  REV = 8'hB4;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1;
  logic        sdio_in = 1'b0;
  logic [7:0]  temp_code = 8'd115;
  logic        sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [63:0] cfg_out;

  spi_regfile_slave #(.DIE_ID(ID), .DIE_REV(REV)) u_spi_regfile_slave (
    .sclk(sclk), .rst_n(rst_n), .csn(csn), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .temp_code(temp_code), .cfg_out(cfg_out)
  );

  always #(PER/2) sclk = ~sclk;

  logic [7:0]  mdl [8];
  logic        mdl_err = 1'b0;
  int          err_byte = -1;
  bit          four_w = 1'b0;
  int          lane = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [63:0] bad_vec;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mdl_vec();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = mdl[k];
    return v;
  endfunction

  function automatic logic [7:0] model_rd(input logic [4:0] a);
    if (a < 5'd8) return mdl[a[2:0]];
    if (a == 5'h08) return temp_code;
    if (a == 5'h09) return {7'b0, mdl_err};
    if (a >= 5'h17 && a <= 5'h1E) return ID[8*(int'(a) - 23) +: 8];
    if (a == 5'h1F) return REV;
    return 8'h00;
  endfunction

  task automatic drive_instr(input bit rd, input int nb, input logic [4:0] a);
    logic [7:0] ins;
    ins = {rd, 2'(nb - 1), a};
    for (int i = 7; i >= 0; i--) begin
      @(negedge sclk);
      csn = 1'b0;
      sdio_in = ins[i];
    end
  endtask

  task automatic wr(input logic [4:0] a, input int nb, input logic [3:0][7:0] d, input int extra);
    logic [4:0] ad;
    drive_instr(1'b0, nb, a);
    for (int k = 0; k < nb + extra; k++)
      for (int i = 7; i >= 0; i--) begin
        @(negedge sclk);
        sdio_in = d[k][i];
      end
    @(negedge sclk);
    csn = 1'b1;
    sdio_in = 1'b0;
    for (int k = 0; k < nb; k++) begin
      ad = a - 5'(k);
      if (ad < 5'd8) begin
        mdl[ad[2:0]] = d[k];
        if (int'(ad) == err_byte) begin mdl_err = 1'b0; err_byte = -1; end
      end
    end
    four_w = mdl[1][3];
  endtask

  task automatic abort_wr(input logic [4:0] a, input logic [7:0] d, input int nbits);
    drive_instr(1'b0, 1, a);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge sclk);
      sdio_in = d[i];
    end
    @(negedge sclk);
    csn = 1'b1;
    sdio_in = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input int nb, input string tag);
    for (int k = 0; k < nb; k++) begin
      exp_q.push_back(model_rd(a - 5'(k)));
      tag_q.push_back(tag);
    end
    drive_instr(1'b1, nb, a);
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) begin
        @(negedge sclk);
        sdio_in = 1'b0;
        if (k == 0 && i == 7) lane = four_w ? 2 : 1;
      end
    @(negedge sclk);
    lane = 0;
    #(PER/4);
    if (four_w)
      check(sdo_oe && !sdo_out && !sdio_oe, "R7 4-wire tail drives sdo low",
            {61'b0, sdo_oe, sdo_out, sdio_oe}, 64'b100);
    else
      check(!sdio_oe && !sdo_oe, "R7 3-wire tail releases sdio",
            {62'b0, sdio_oe, sdo_oe}, 64'b0);
    @(negedge sclk);
    csn = 1'b1;
    #(PER/4);
    check(!sdo_oe && !sdio_oe, "R7 lines released after csn high",
          {62'b0, sdo_oe, sdio_oe}, 64'b0);
  endtask

  initial begin : monitor
    logic [7:0] acc;
    logic [7:0] e;
    string      t;
    int         n;
    acc = '0;
    n = 0;
    forever begin
      @(negedge sclk);
      #(PER/4);
      if (lane != 0) begin
        acc = {acc[6:0], (lane == 2) ? sdo_out : sdio_out};
        if (lane == 2)
          check(sdo_oe && !sdio_oe, "R6 4-wire enables", {62'b0, sdo_oe, sdio_oe}, 64'b10);
        else
          check(sdio_oe && !sdo_oe, "R6 3-wire enables", {62'b0, sdio_oe, sdo_oe}, 64'b10);
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected read byte", {56'b0, acc}, 64'b0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(acc == e, {t, " read byte"}, {56'b0, acc}, {56'b0, e});
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(PER * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
    mdl[5] = 8'h20;
    mdl[6] = 8'h04;
    repeat (4) @(negedge sclk);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    #(PER/4);
    check(cfg_out == mdl_vec(), "R5 reset configuration", cfg_out, mdl_vec());
    check(!sdo_oe && !sdio_oe, "R7 idle enables", {62'b0, sdo_oe, sdio_oe}, 64'b0);

    rd(5'h06, 2, "R5 R3");

    wr(5'h00, 1, {8'h00, 8'h00, 8'h00, 8'hA5}, 0);
    check(cfg_out == mdl_vec(), "R1 R12 single write", cfg_out, mdl_vec());
    rd(5'h00, 1, "R1");

    wr(5'h07, 4, {8'h44, 8'h33, 8'h22, 8'h11}, 0);
    check(cfg_out == mdl_vec(), "R4 four-byte descending write", cfg_out, mdl_vec());

    wr(5'h03, 2, {8'h00, 8'hEE, 8'h3D, 8'h5C}, 1);
    check(cfg_out == mdl_vec(), "R2 extra byte ignored", cfg_out, mdl_vec());

    abort_wr(5'h00, 8'h0F, 5);
    check(cfg_out == mdl_vec(), "R11 abort after 5 bits", cfg_out, mdl_vec());
    abort_wr(5'h04, 8'hFF, 7);
    check(cfg_out == mdl_vec(), "R11 abort after 7 bits", cfg_out, mdl_vec());

    wr(5'h0C, 2, {8'h00, 8'h00, 8'hFF, 8'hFF}, 0);
    wr(5'h0A, 3, {8'h00, 8'h77, 8'h01, 8'h99}, 0);
    wr(5'h1F, 1, {8'h00, 8'h00, 8'h00, 8'hFF}, 0);
    check(cfg_out == mdl_vec(), "R8 read-only writes ignored", cfg_out, mdl_vec());
    rd(5'h0D, 1, "R8");
    rd(5'h0A, 3, "R8 R9");
    rd(5'h1E, 4, "R8");

    temp_code = 8'hAF;
    rd(5'h08, 1, "R9");

    wr(5'h01, 1, {8'h00, 8'h00, 8'h00, 8'h08}, 0);
    rd(5'h01, 4, "R4 R6");
    rd(5'h05, 2, "R6");

    bad_vec = mdl_vec() ^ (64'h1 << 20);
    force u_spi_regfile_slave.u_cfg.g_copy[2].u_bank.mem_q = bad_vec;
    mdl_err = 1'b1;
    err_byte = 2;
    rd(5'h09, 1, "R10");
    rd(5'h02, 1, "R10");
    #(PER/4);
    check(cfg_out == mdl_vec(), "R10 voted outputs", cfg_out, mdl_vec());
    release u_spi_regfile_slave.u_cfg.g_copy[2].u_bank.mem_q;
    wr(5'h02, 1, {8'h00, 8'h00, 8'h00, 8'h3D}, 0);
    rd(5'h09, 1, "R10");

    wr(5'h01, 1, {8'h00, 8'h00, 8'h00, 8'h00}, 0);
    rd(5'h1F, 1, "R3 R6");

    repeat (4) @(negedge sclk);
    check(exp_q.size() == 0, "R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule